// File: doc/BRIEF.md
# Multi-Address I2C Target Controller

This block is the target (slave) side of an I2C bus. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and shifts in the address byte. It acknowledges that byte when the 7-bit address equals a primary address, or one of several extra addresses whose enable bit is set, or the all-zero general call when that response is enabled. After a write address it receives bytes and acknowledges each one with a value software selects. After a read address it shifts bytes out of a data register until the controller answers with NACK.

Software reaches the block through a small parallel register port. The port carries a control word, the address registers, transmit data, received data and a command/status word. Clock stretching holds SCL low at the end of each byte, either after the 8th or after the 9th SCL falling edge. The stretch lasts until software writes a release strobe. This lets software look at a received byte and choose its acknowledge before the controller can continue. While a transfer is in progress, the control bits that change the bus behaviour are locked.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0001, which means only the enable bit is set. Status (address 7) reads 0, and neither SCL nor SDA is driven.
- R2: An address byte whose upper 7 bits equal the primary address (address 1, bits 6:0) is acknowledged. The mode bit (control bit 9) then shows that byte's R/W bit (bit 0), where 1 means read.
- R3: Extra addresses 1..3 live at register addresses 2..4 and are enabled by control bits 6..8. An extra address is acknowledged only while its own enable bit is 1.
- R4: The address byte 0x00 is acknowledged only when the general-call bit (control bit 1) is 1. The byte 0x01 is never treated as a general call.
- R5: In a write transfer, the acknowledge slot after each data byte pulls SDA low when the NACK-select bit (control bit 2) is 0 and leaves SDA released when it is 1. The value in force when the slot is driven applies, including a value written during a stretch. The byte is readable at address 6.
- R6: When stretch-enable (control bit 3) is 1, SCL is held low after the 8th falling edge of each byte if stretch-at-8 (control bit 4) is 1, or after the 9th falling edge if it is 0. Status bit 0 shows the hold, and writing 1 to bit 0 of address 7 releases it.
- R7: With stretch-enable 0, SCL is never held, whatever the value of stretch-at-8.
- R8: Status bit 1 (busy) is 1 from a START until the next STOP. A STOP releases both SCL and SDA.
- R9: While busy, writes to the enable, general-call, stretch-enable and stretch-at-8 bits are ignored. NACK-select, timeout-enable and the extra-address enables still take new values.
- R10: In a read transfer the target sends the transmit register (address 5) MSB first and reloads it after each controller ACK. After a controller NACK it leaves SDA released.
- R11: With the enable bit (control bit 0) at 0, no address is acknowledged.
- R12: Control bit 5 is the timeout-enable and appears on the `tmo_en` output. Control bits 15:10 read 0.
- R13: The mode bit is read-only. Writing 1 to control bit 9 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| tmo_en | output | 1 | Timeout-enable bit for external timeout logic |

## Verification
Some properties are checked on every cycle. Busy follows START and STOP, and a STOP leaves both lines released. An address is never acknowledged while the block is disabled. A stretch never starts without stretch-enable, and no SCL rising edge is seen while a stretch is held. The enable bit cannot change while busy. Other behaviour depends on a whole bus sequence and only the bench scenarios show it. This covers which address and enable combinations are acknowledged, which falling edge starts a stretch, a late change of the acknowledge value, the transmitted bit order and reload, and what reads back after writes that are blocked.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } bus_st_e;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_GC   = 1;
  localparam int CB_NACK = 2;
  localparam int CB_STR  = 3;
  localparam int CB_AT8  = 4;
  localparam int CB_TMO  = 5;
  localparam int CB_XEN  = 6;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;
  logic              scl_s;

  // idle bus is high, so reset to 1 to avoid false edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
  parameter int N_EXT = 3
) (
  input  logic [7:0]            abyte,
  input  logic                  gc_en,
  input  logic [6:0]            own_addr,
  input  logic [N_EXT-1:0]      ext_en,
  input  logic [N_EXT-1:0][6:0] ext_addr,
  output logic                  hit
);

  logic [N_EXT-1:0] ext_hit;
  logic             own_hit, gc_hit;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_hit[g] = ext_en[g] & (abyte[7:1] == ext_addr[g]);
  end

  assign own_hit = (abyte[7:1] == own_addr);
  assign gc_hit  = gc_en & (abyte == 8'h00);
  assign hit     = own_hit | gc_hit | (|ext_hit);

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic                  busy,
  input  logic                  hold,
  input  logic                  rw_mode,
  input  logic [7:0]            rx_data,
  output logic                  en,
  output logic                  gc_en,
  output logic                  nack_sel,
  output logic                  str_en,
  output logic                  str_at8,
  output logic                  tmo_en,
  output logic [N_EXT-1:0]      ext_en,
  output logic [6:0]            own_addr,
  output logic [N_EXT-1:0][6:0] ext_addr,
  output logic [7:0]            tx_data,
  output logic                  release_str
);

  localparam int A_CTRL   = 0;
  localparam int A_OWN    = 1;
  localparam int A_EXT    = 2;
  localparam int A_TX     = A_EXT + N_EXT;
  localparam int A_RX     = A_TX + 1;
  localparam int A_CMD    = A_RX + 1;
  localparam int MODE_BIT = CB_XEN + N_EXT;

  logic en_q, gc_q, nack_q, str_q, at8_q, tmo_q;
  logic en_d, gc_d, nack_d, str_d, at8_d, tmo_d;
  logic [N_EXT-1:0]      xen_q, xen_d;
  logic [6:0]            own_q, own_d;
  logic [N_EXT-1:0][6:0] ext_q, ext_d;
  logic [7:0]            tx_q, tx_d;
  logic                  ctrl_wr;
  logic                  wdata_unused;

  assign ctrl_wr      = we & (addr == AW'(A_CTRL));
  assign wdata_unused = ^wdata[DW-1:MODE_BIT];

  always_comb begin
    en_d   = en_q;
    gc_d   = gc_q;
    nack_d = nack_q;
    str_d  = str_q;
    at8_d  = at8_q;
    tmo_d  = tmo_q;
    xen_d  = xen_q;
    own_d  = own_q;
    ext_d  = ext_q;
    tx_d   = tx_q;
    if (ctrl_wr) begin
      nack_d = wdata[CB_NACK];
      tmo_d  = wdata[CB_TMO];
      xen_d  = wdata[CB_XEN +: N_EXT];
      if (!busy) begin
        en_d  = wdata[CB_EN];
        gc_d  = wdata[CB_GC];
        str_d = wdata[CB_STR];
        at8_d = wdata[CB_AT8];
      end
    end
    if (we && addr == AW'(A_OWN)) own_d = wdata[6:0];
    if (we && addr == AW'(A_TX))  tx_d  = wdata[7:0];
    for (int i = 0; i < N_EXT; i++) begin
      if (we && addr == AW'(A_EXT + i)) ext_d[i] = wdata[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      gc_q   <= 1'b0;
      nack_q <= 1'b0;
      str_q  <= 1'b0;
      at8_q  <= 1'b0;
      tmo_q  <= 1'b0;
      xen_q  <= '0;
      own_q  <= '0;
      ext_q  <= '0;
      tx_q   <= '0;
    end else begin
      en_q   <= en_d;
      gc_q   <= gc_d;
      nack_q <= nack_d;
      str_q  <= str_d;
      at8_q  <= at8_d;
      tmo_q  <= tmo_d;
      xen_q  <= xen_d;
      own_q  <= own_d;
      ext_q  <= ext_d;
      tx_q   <= tx_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL)) begin
      rdata[CB_EN]           = en_q;
      rdata[CB_GC]           = gc_q;
      rdata[CB_NACK]         = nack_q;
      rdata[CB_STR]          = str_q;
      rdata[CB_AT8]          = at8_q;
      rdata[CB_TMO]          = tmo_q;
      rdata[CB_XEN +: N_EXT] = xen_q;
      rdata[MODE_BIT]        = rw_mode;
    end
    if (addr == AW'(A_OWN)) rdata[6:0] = own_q;
    if (addr == AW'(A_TX))  rdata[7:0] = tx_q;
    if (addr == AW'(A_RX))  rdata[7:0] = rx_data;
    if (addr == AW'(A_CMD)) rdata[1:0] = {busy, hold};
    for (int i = 0; i < N_EXT; i++) begin
      if (addr == AW'(A_EXT + i)) rdata[6:0] = ext_q[i];
    end
  end

  assign release_str = we & (addr == AW'(A_CMD)) & wdata[0];
  assign en          = en_q;
  assign gc_en       = gc_q;
  assign nack_sel    = nack_q;
  assign str_en      = str_q;
  assign str_at8     = at8_q;
  assign tmo_en      = tmo_q;
  assign ext_en      = xen_q;
  assign own_addr    = own_q;
  assign ext_addr    = ext_q;
  assign tx_data     = tx_q;

  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(en_q)); // R9

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  stop,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_s,
  input  logic                  en,
  input  logic                  gc_en,
  input  logic                  nack_sel,
  input  logic                  str_en,
  input  logic                  str_at8,
  input  logic [N_EXT-1:0]      ext_en,
  input  logic [6:0]            own_addr,
  input  logic [N_EXT-1:0][6:0] ext_addr,
  input  logic [7:0]            tx_data,
  input  logic                  release_str,
  output logic                  busy,
  output logic                  hold,
  output logic                  rw_mode,
  output logic [7:0]            rx_data,
  output logic                  scl_oe,
  output logic                  sda_oe
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  bus_st_e    st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] txsh_q, txsh_d;
  logic [7:0] rx_q, rx_d;
  logic       busy_q, busy_d;
  logic       hold_q, hold_d;
  logic       rw_q, rw_d;
  logic       mack_q, mack_d;
  logic       hit;
  logic       at8_hold, at9_hold;

  i2c_tgt_match #(.N_EXT(N_EXT)) u_match (
    .abyte    (sh_q),
    .gc_en    (gc_en),
    .own_addr (own_addr),
    .ext_en   (ext_en),
    .ext_addr (ext_addr),
    .hit      (hit)
  );

  assign at8_hold = str_en & str_at8;
  assign at9_hold = str_en & ~str_at8;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    txsh_d = txsh_q;
    rx_d   = rx_q;
    busy_d = busy_q;
    hold_d = hold_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    if (release_str) hold_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      hold_d = 1'b0;
      cnt_d  = '0;
      sh_d   = '0;
      st_d   = en ? ST_ADDR : ST_SKIP;
    end else if (stop) begin
      busy_d = 1'b0;
      hold_d = 1'b0;
      st_d   = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = 4'(cnt_q + 4'd1);
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_RX) begin
              st_d = ST_RX_ACK;
              rx_d = sh_q;
              if (at8_hold) hold_d = 1'b1;
            end else if (hit) begin
              st_d = ST_ADDR_ACK;
              rw_d = sh_q[0];
              if (at8_hold) hold_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_rise) begin
            cnt_d = ACK_BIT;
          end else if (scl_fall && cnt_q == ACK_BIT) begin
            cnt_d = '0;
            if (at9_hold) hold_d = 1'b1;
            if (st_q == ST_ADDR_ACK && rw_q) begin
              st_d   = ST_TX;
              txsh_d = tx_data;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = 4'(cnt_q + 4'd1);
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_d = ST_TX_ACK;
              if (at8_hold) hold_d = 1'b1;
            end else begin
              txsh_d = {txsh_q[6:0], 1'b1};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            cnt_d  = ACK_BIT;
            mack_d = ~sda_s;
          end else if (scl_fall && cnt_q == ACK_BIT) begin
            if (mack_q) begin
              st_d   = ST_TX;
              txsh_d = tx_data;
              cnt_d  = '0;
              if (at9_hold) hold_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      txsh_q <= '1;
      rx_q   <= '0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      txsh_q <= txsh_d;
      rx_q   <= rx_d;
      busy_q <= busy_d;
      hold_q <= hold_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
    end
  end

  // acknowledge value is taken live so a late software update applies
  assign sda_oe  = (st_q == ST_ADDR_ACK) |
                   ((st_q == ST_RX_ACK) & ~nack_sel) |
                   ((st_q == ST_TX) & ~txsh_q[7]);
  assign scl_oe  = hold_q;
  assign busy    = busy_q;
  assign hold    = hold_q;
  assign rw_mode = rw_q;
  assign rx_data = rx_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R8
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy_q && !scl_oe && !sda_oe)); // R8
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR_ACK) |-> en); // R11
  AST_HOLD_NEEDS_STR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> str_en); // R7
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !scl_rise); // R6

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl #(
  parameter int N_EXT       = 3,
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tmo_en
);

  logic [1:0]            rst_pipe;
  logic                  rst_n_s;
  logic                  sda_s, start, stop, scl_rise, scl_fall;
  logic                  en, gc_en, nack_sel, str_en, str_at8, release_str;
  logic                  busy, hold, rw_mode;
  logic [N_EXT-1:0]      ext_en;
  logic [6:0]            own_addr;
  logic [N_EXT-1:0][6:0] ext_addr;
  logic [7:0]            tx_data, rx_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .start    (start),
    .stop     (stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_tgt_regs #(.N_EXT(N_EXT), .DW(DW), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .busy        (busy),
    .hold        (hold),
    .rw_mode     (rw_mode),
    .rx_data     (rx_data),
    .en          (en),
    .gc_en       (gc_en),
    .nack_sel    (nack_sel),
    .str_en      (str_en),
    .str_at8     (str_at8),
    .tmo_en      (tmo_en),
    .ext_en      (ext_en),
    .own_addr    (own_addr),
    .ext_addr    (ext_addr),
    .tx_data     (tx_data),
    .release_str (release_str)
  );

  i2c_tgt_fsm #(.N_EXT(N_EXT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .stop        (stop),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .sda_s       (sda_s),
    .en          (en),
    .gc_en       (gc_en),
    .nack_sel    (nack_sel),
    .str_en      (str_en),
    .str_at8     (str_at8),
    .ext_en      (ext_en),
    .own_addr    (own_addr),
    .ext_addr    (ext_addr),
    .tx_data     (tx_data),
    .release_str (release_str),
    .busy        (busy),
    .hold        (hold),
    .rw_mode     (rw_mode),
    .rx_data     (rx_data),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
  );

endmodule

// File: tb/i2c_tgt_ctrl_test.sv
module i2c_tgt_ctrl_test;

  localparam int Q = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        scl_oe, sda_oe, tmo_en;
  wire         scl_bus = scl_m & ~scl_oe;
  wire         sda_bus = sda_m & ~sda_oe;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic        rbit;
  logic [7:0]  rbyte;
  logic [15:0] rd;

  always #5 clk = ~clk;

  i2c_tgt_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_bus),
    .sda_i     (sda_bus),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .reg_we    (we),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .tmo_en    (tmo_en)
  );

  // fields: control word, address byte, expected acknowledge
  localparam logic [24:0] VECS [12] = '{
    {16'h0001, 8'h54, 1'b1},  // R2 primary, write
    {16'h0001, 8'h55, 1'b1},  // R2 primary, read
    {16'h0001, 8'h44, 1'b0},  // R3 extra 2 disabled
    {16'h0081, 8'h44, 1'b1},  // R3 extra 2 enabled
    {16'h0041, 8'h44, 1'b0},  // R3 only extra 1 enabled
    {16'h0041, 8'h22, 1'b1},  // R3 extra 1 enabled
    {16'h0101, 8'h66, 1'b1},  // R3 extra 3 enabled
    {16'h0001, 8'h00, 1'b0},  // R4 general call off
    {16'h0003, 8'h00, 1'b1},  // R4 general call on
    {16'h0003, 8'h01, 1'b0},  // R4 read bit is no general call
    {16'h0000, 8'h54, 1'b0},  // R11 disabled
    {16'h01C3, 8'h7E, 1'b0}   // R3 no address matches
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a);
    addr = a;
    #1 rd = rdata;
  endtask

  task automatic clk_bit(input logic b);
    sda_m = b;
    tick(Q);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(Q);
    rbit = sda_bus;
    scl_m = 1'b0;
    tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    sda_m = 1'b1;
  endtask

  task automatic get_byte();
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1);
      rbyte = {rbyte[6:0], rbit};
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    reg_rd(3'd0); chk("R1 control", rd, 16'h0001);
    reg_rd(3'd7); chk("R1 status", rd, 16'h0000);
    chk("R1 scl_oe", {15'd0, scl_oe}, 16'd0);
    chk("R1 sda_oe", {15'd0, sda_oe}, 16'd0);

    // R12 R13 reserved and mode bits do not take writes
    reg_wr(3'd0, 16'hFFFF);
    reg_rd(3'd0); chk("R12 R13 readback", rd, 16'h01FF);
    chk("R12 tmo_en", {15'd0, tmo_en}, 16'd1);
    reg_wr(3'd0, 16'h0001);

    reg_wr(3'd1, 16'h002A);
    reg_wr(3'd2, 16'h0011);
    reg_wr(3'd3, 16'h0022);
    reg_wr(3'd4, 16'h0033);
    reg_wr(3'd5, 16'h00FF);

    // address matching table
    foreach (VECS[k]) begin
      reg_wr(3'd0, VECS[k][24:9]);
      i2c_start();
      put_byte(VECS[k][8:1]);
      clk_bit(1'b1);
      chk("R2 R3 R4 R11 address ack", {15'd0, ~rbit}, {15'd0, VECS[k][0]});
      if (VECS[k][0]) begin
        reg_rd(3'd0);
        chk("R2 mode bit", {15'd0, rd[9]}, {15'd0, VECS[k][1]});
      end
      i2c_stop();
    end

    // R5 R8 R9 receive with acknowledge control
    reg_wr(3'd0, 16'h0001);
    i2c_start();
    reg_rd(3'd7); chk("R8 busy after start", rd, 16'h0002);
    put_byte(8'h54); clk_bit(1'b1);
    chk("R2 write address ack", {15'd0, rbit}, 16'd0);
    put_byte(8'hA5); clk_bit(1'b1);
    chk("R5 data ack", {15'd0, rbit}, 16'd0);
    reg_rd(3'd6); chk("R5 rx byte", rd, 16'h00A5);
    reg_wr(3'd0, 16'h003E);
    reg_rd(3'd0); chk("R9 locked bits while busy", rd, 16'h0025);
    put_byte(8'h3C); clk_bit(1'b1);
    chk("R5 data nack", {15'd0, rbit}, 16'd1);
    reg_rd(3'd6); chk("R5 rx byte 2", rd, 16'h003C);
    i2c_stop();
    reg_rd(3'd7); chk("R8 idle after stop", rd, 16'h0000);
    chk("R8 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);

    // R6 stretch after 9th falling edge
    reg_wr(3'd0, 16'h0009);
    i2c_start();
    put_byte(8'h54);
    chk("R6 no hold at 8th", {15'd0, scl_oe}, 16'd0);
    clk_bit(1'b1);
    chk("R6 addr ack", {15'd0, rbit}, 16'd0);
    chk("R6 hold at 9th", {15'd0, scl_oe}, 16'd1);
    reg_rd(3'd7); chk("R6 status hold", rd, 16'h0003);
    reg_wr(3'd7, 16'h0001);
    chk("R6 released", {15'd0, scl_oe}, 16'd0);
    put_byte(8'h5A); clk_bit(1'b1);
    chk("R6 data hold at 9th", {15'd0, scl_oe}, 16'd1);
    reg_wr(3'd7, 16'h0001);
    reg_rd(3'd6); chk("R5 rx under stretch", rd, 16'h005A);
    i2c_stop();

    // R6 R5 stretch after 8th edge, acknowledge chosen during the hold
    reg_wr(3'd0, 16'h001D);
    i2c_start();
    put_byte(8'h54);
    chk("R6 addr hold at 8th", {15'd0, scl_oe}, 16'd1);
    reg_wr(3'd7, 16'h0001);
    clk_bit(1'b1);
    chk("R6 addr ack", {15'd0, rbit}, 16'd0);
    chk("R6 no hold at 9th", {15'd0, scl_oe}, 16'd0);
    put_byte(8'h77);
    chk("R6 data hold at 8th", {15'd0, scl_oe}, 16'd1);
    chk("R5 nack pending", {15'd0, sda_oe}, 16'd0);
    reg_wr(3'd0, 16'h0019);
    chk("R5 late ack drives", {15'd0, sda_oe}, 16'd1);
    reg_wr(3'd7, 16'h0001);
    clk_bit(1'b1);
    chk("R5 late ack on bus", {15'd0, rbit}, 16'd0);
    i2c_stop();

    // R7 stretch-select alone has no effect
    reg_wr(3'd0, 16'h0011);
    i2c_start();
    put_byte(8'h54);
    chk("R7 no hold at 8th", {15'd0, scl_oe}, 16'd0);
    clk_bit(1'b1);
    chk("R7 no hold at 9th", {15'd0, scl_oe}, 16'd0);
    reg_rd(3'd7); chk("R7 status", rd, 16'h0002);
    i2c_stop();

    // R10 transmit
    reg_wr(3'd5, 16'h00B4);
    reg_wr(3'd0, 16'h0001);
    i2c_start();
    put_byte(8'h55); clk_bit(1'b1);
    chk("R10 read address ack", {15'd0, rbit}, 16'd0);
    reg_rd(3'd0); chk("R2 read mode", rd, 16'h0201);
    get_byte();
    chk("R10 first byte", {8'd0, rbyte}, 16'h00B4);
    clk_bit(1'b0);
    get_byte();
    chk("R10 reloaded byte", {8'd0, rbyte}, 16'h00B4);
    clk_bit(1'b1);
    chk("R10 released after nack", {15'd0, sda_oe}, 16'd0);
    clk_bit(1'b1);
    chk("R10 bus stays high", {15'd0, rbit}, 16'd1);
    i2c_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule